// File: doc/BRIEF.md
# Sequence Interval Timer with Prescaled Time Base

This block spaces successive update sequences of a multi-channel converter by a programmable interval. Software writes a 16-bit interval count into a preload register through a simple 32-bit register port. A prescaler divides the 40 MHz system clock by 4000 into a 100 µs tick. While the control logic holds the block in sequencer-update mode, a down-counter measures preload × 100 µs and then emits a one-cycle `next_seq` strobe. That strobe starts the next sequence and reloads the counter, so the interval spans 100 µs to 6.5535 s in 100 µs steps.

A three-state controller drives the timer. **ST_IDLE** is the state outside sequencer-update mode. **ST_WAIT** means the mode is selected but the preload is zero, so the timer is blocked. **ST_RUN** means the timer is counting.

The transitions are:
- **start**: ST_IDLE or ST_WAIT goes to ST_RUN when the mode is on and the preload is non-zero.
- **block**: ST_IDLE goes to ST_WAIT when the mode is on and the preload is zero.
- **expire-reload**: ST_RUN stays in ST_RUN at the terminal tick when the preload is non-zero.
- **expire-park**: ST_RUN goes to ST_WAIT at the terminal tick when the preload is zero.
- **abort**: ST_RUN or ST_WAIT goes to ST_IDLE when the mode drops.

Every load clears the prescaler, so each interval is exactly preload × divider clock cycles.

Top module: `seqtmr_top`

## Requirements
- R1: The preload register sits at word index 0. It holds CNT_W bits taken from the low bits of the written word, resets to 0, and reads back the stored value.
- R2: Write-data bits at and above CNT_W are ignored, and read-data bits at and above CNT_W are always zero. Word index 1 is a read-only status word with bit 0 = busy (1 while counting) and every other bit zero. All other indices read as zero.
- R3: The first clock edge that sees sequencer-update mode on and a non-zero preload loads the counter and starts the timer. Busy is 1 from the next cycle on.
- R4: While the preload is zero, selecting the mode does not start the timer: busy stays 0 and no strobe appears. Writing a non-zero preload with the mode still held starts the timer on the edge after the write.
- R5: The `next_seq` strobe is one cycle wide. It is high in the PRESCALE_DIV × P-th cycle counted from the first busy cycle. It then repeats every PRESCALE_DIV × P cycles, because the counter reloads at every sequence start.
- R6: A preload written while counting does not change the interval already running. It sets the length of the interval that follows the next reload.
- R7: Dropping the mode stops the counter and the prescaler at the next edge, with no strobe in that cycle or after. Re-selecting the mode starts a full fresh interval.
- R8: A synchronous reset clears the preload, stops the timer and suppresses the strobe.
- R9: If the preload is zero when the count expires, the strobe is still issued. The timer then parks in ST_WAIT with busy 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (40 MHz time base by default) |
| rst | input | 1 | Synchronous reset, active high |
| seq_mode | input | 1 | Sequencer-update mode selected by the control logic |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe; data is valid in the following cycle |
| reg_addr | input | ADDR_W | Register word index |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Registered read data |
| next_seq | output | 1 | One-cycle strobe that starts the next sequence |
| busy | output | 1 | Timer is counting |

## Verification
The bench builds the block with PRESCALE_DIV = 4 and CNT_W = 4, so a full interval lasts at most 60 cycles. At that size every non-zero preload from 1 to 15 can be swept over two consecutive intervals, and the bench checks the strobe position and width on every cycle against P × 4. The narrow counter also puts the register truncation boundary at bit 4, where the masking of write data and the zeroing of read data are easy to observe. The same small configuration keeps short the scenarios for a mid-interval preload change, a zero preload at expiry, mode abort and reset.

// File: rtl/seqtmr_pkg.sv
package seqtmr_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_RUN  = 2'd2
    } seq_state_e;

    localparam int unsigned REG_PRELOAD     = 0;
    localparam int unsigned REG_STATUS      = 1;
    localparam int unsigned STATUS_BUSY_BIT = 0;

endpackage

// File: rtl/seqtmr_regs.sv
module seqtmr_regs #(
    parameter int unsigned CNT_W  = 16,
    parameter int unsigned ADDR_W = 4,
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic              busy,
    output logic [CNT_W-1:0]  preload,
    output logic [DATA_W-1:0] reg_rdata
);
    import seqtmr_pkg::*;

    localparam logic [ADDR_W-1:0] A_PRELOAD = ADDR_W'(REG_PRELOAD);
    localparam logic [ADDR_W-1:0] A_STATUS  = ADDR_W'(REG_STATUS);

    logic [CNT_W-1:0]  preload_q;
    logic [DATA_W-1:0] rd_mux;
    logic              unused_wr_upper;

    // upper write bits have no storage
    assign unused_wr_upper = ^reg_wdata[DATA_W-1:CNT_W];

    always_ff @(posedge clk) begin
        if (rst) begin
            preload_q <= '0;
        end else if (reg_wr && reg_addr == A_PRELOAD) begin
            preload_q <= reg_wdata[CNT_W-1:0];
        end
    end

    always_comb begin
        rd_mux = '0;
        if (reg_addr == A_PRELOAD) begin
            rd_mux[CNT_W-1:0] = preload_q;
        end else if (reg_addr == A_STATUS) begin
            rd_mux[STATUS_BUSY_BIT] = busy;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            reg_rdata <= '0;
        end else if (reg_rd) begin
            reg_rdata <= rd_mux;
        end
    end

    assign preload = preload_q;

endmodule

// File: rtl/seqtmr_prescale.sv
module seqtmr_prescale #(
    parameter int unsigned PRESCALE_DIV = 4000
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic clr,
    output logic tick
);
    localparam int unsigned PRE_W = (PRESCALE_DIV > 2) ? $clog2(PRESCALE_DIV) : 1;
    localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(PRESCALE_DIV - 1);

    logic [PRE_W-1:0] pre_q;

    always_ff @(posedge clk) begin
        if (rst || clr || !run) begin
            pre_q <= '0;
        end else if (pre_q == PRE_LAST) begin
            pre_q <= '0;
        end else begin
            pre_q <= pre_q + 1'b1;
        end
    end

    assign tick = run && (pre_q == PRE_LAST);

endmodule

// File: rtl/seqtmr_fsm.sv
module seqtmr_fsm #(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             seq_mode,
    input  logic [CNT_W-1:0] preload,
    input  logic             tick,
    output logic             load,
    output logic             strobe,
    output logic             busy
);
    import seqtmr_pkg::*;

    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    seq_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             pre_nz;
    logic             last_tick;

    assign pre_nz    = (preload != '0);
    assign last_tick = tick && (cnt_q == CNT_ONE);

    // state register and counter
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (seq_mode) state_d = pre_nz ? ST_RUN : ST_WAIT;
            end
            ST_WAIT: begin
                if (!seq_mode)   state_d = ST_IDLE;
                else if (pre_nz) state_d = ST_RUN;
            end
            ST_RUN: begin
                if (!seq_mode)      state_d = ST_IDLE;
                else if (last_tick) state_d = pre_nz ? ST_RUN : ST_WAIT;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        load   = 1'b0;
        strobe = 1'b0;
        busy   = 1'b0;
        unique case (state_q)
            ST_IDLE, ST_WAIT: begin
                load = seq_mode && pre_nz;
            end
            ST_RUN: begin
                busy   = 1'b1;
                strobe = seq_mode && last_tick;
                load   = seq_mode && last_tick && pre_nz;
            end
            default: ;
        endcase
    end

    // down-counter
    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = preload;
        end else if (state_d != ST_RUN) begin
            cnt_d = '0;
        end else if (tick) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

endmodule

// File: rtl/seqtmr_top.sv
module seqtmr_top #(
    parameter int unsigned CNT_W        = 16,
    parameter int unsigned PRESCALE_DIV = 4000,
    parameter int unsigned ADDR_W       = 4,
    parameter int unsigned DATA_W       = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              seq_mode,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              next_seq,
    output logic              busy
);
    logic [CNT_W-1:0] preload_q;
    logic             tick;
    logic             load;

    seqtmr_regs #(
        .CNT_W (CNT_W),
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W)
    ) u_regs (
        .clk      (clk),
        .rst      (rst),
        .reg_wr   (reg_wr),
        .reg_rd   (reg_rd),
        .reg_addr (reg_addr),
        .reg_wdata(reg_wdata),
        .busy     (busy),
        .preload  (preload_q),
        .reg_rdata(reg_rdata)
    );

    seqtmr_prescale #(
        .PRESCALE_DIV(PRESCALE_DIV)
    ) u_pre (
        .clk (clk),
        .rst (rst),
        .run (busy),
        .clr (load),
        .tick(tick)
    );

    seqtmr_fsm #(
        .CNT_W(CNT_W)
    ) u_fsm (
        .clk     (clk),
        .rst     (rst),
        .seq_mode(seq_mode),
        .preload (preload_q),
        .tick    (tick),
        .load    (load),
        .strobe  (next_seq),
        .busy    (busy)
    );

endmodule

// File: rtl/seqtmr_checker.sv
module seqtmr_checker #(
    parameter int unsigned CNT_W  = 16,
    parameter int unsigned DATA_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              seq_mode,
    input logic              busy,
    input logic              next_seq,
    input logic [CNT_W-1:0]  preload,
    input logic [DATA_W-1:0] reg_rdata
);

    // R5: strobe lasts a single cycle
    a_r5_strobe_single: assert property (@(posedge clk) disable iff (rst)
        next_seq |=> !next_seq);

    // R5: strobe only while counting
    a_r5_strobe_busy: assert property (@(posedge clk) disable iff (rst)
        next_seq |-> busy);

    // R4: zero preload keeps an idle timer idle
    a_r4_zero_blocks: assert property (@(posedge clk) disable iff (rst)
        (!busy && preload == '0) |=> !busy);

    // R7: mode off stops the count at the next edge
    a_r7_mode_stop: assert property (@(posedge clk) disable iff (rst)
        !seq_mode |=> !busy);

    // R7: no strobe without the mode
    a_r7_no_strobe: assert property (@(posedge clk) disable iff (rst)
        !seq_mode |-> !next_seq);

    // R2: read data upper bits stay zero
    a_r2_upper_zero: assert property (@(posedge clk) disable iff (rst)
        reg_rdata[DATA_W-1:CNT_W] == '0);

    // R8: reset clears preload and stops the timer
    a_r8_reset_clears: assert property (@(posedge clk)
        rst |=> (!busy && preload == '0 && !next_seq));

endmodule

bind seqtmr_top seqtmr_checker #(
    .CNT_W (CNT_W),
    .DATA_W(DATA_W)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .seq_mode (seq_mode),
    .busy     (busy),
    .next_seq (next_seq),
    .preload  (preload_q),
    .reg_rdata(reg_rdata)
);

// File: tb/seqtmr_top_test.sv
module seqtmr_top_test;

    localparam int unsigned CNT_W  = 4;
    localparam int unsigned DIV    = 4;
    localparam int unsigned ADDR_W = 4;
    localparam int unsigned DATA_W = 32;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              seq_mode = 1'b0;
    logic              reg_wr = 1'b0;
    logic              reg_rd = 1'b0;
    logic [ADDR_W-1:0] reg_addr = '0;
    logic [DATA_W-1:0] reg_wdata = '0;
    logic [DATA_W-1:0] reg_rdata;
    logic              next_seq;
    logic              busy;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    seqtmr_top #(
        .CNT_W       (CNT_W),
        .PRESCALE_DIV(DIV),
        .ADDR_W      (ADDR_W),
        .DATA_W      (DATA_W)
    ) uut (
        .clk      (clk),
        .rst      (rst),
        .seq_mode (seq_mode),
        .reg_wr   (reg_wr),
        .reg_rd   (reg_rd),
        .reg_addr (reg_addr),
        .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata),
        .next_seq (next_seq),
        .busy     (busy)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic wr_reg(input int a, input logic [31:0] d);
        reg_wr    = 1'b1;
        reg_addr  = ADDR_W'(a);
        reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_reg(input int a, output logic [31:0] v);
        reg_rd   = 1'b1;
        reg_addr = ADDR_W'(a);
        @(negedge clk);
        reg_rd = 1'b0;
        v = reg_rdata;
    endtask

    task automatic expect_quiet(input int n, input string req);
        for (int k = 1; k <= n; k++) begin
            @(negedge clk);
            check(busy == 1'b0, req, 32'(busy), 32'd0);
            check(next_seq == 1'b0, req, 32'(next_seq), 32'd0);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        int          iv;

        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R8 reset state
        check(busy == 1'b0, "R8 reset busy", 32'(busy), 32'd0);
        check(next_seq == 1'b0, "R8 reset strobe", 32'(next_seq), 32'd0);
        rd_reg(0, v); check(v == 32'd0, "R1 reset preload", v, 32'd0);
        rd_reg(1, v); check(v == 32'd0, "R2 reset status", v, 32'd0);

        // R1 / R2 register access
        wr_reg(0, 32'hFFFF_FFF5);
        rd_reg(0, v); check(v == 32'h5, "R2 upper write bits ignored", v, 32'h5);
        wr_reg(0, 32'h0000_000A);
        rd_reg(0, v); check(v == 32'hA, "R1 readback", v, 32'hA);
        rd_reg(2, v); check(v == 32'd0, "R2 unmapped index 2", v, 32'd0);
        rd_reg(3, v); check(v == 32'd0, "R2 unmapped index 3", v, 32'd0);
        wr_reg(1, 32'hFFFF_FFFF);
        rd_reg(1, v); check(v == 32'd0, "R2 status read-only", v, 32'd0);
        rd_reg(0, v); check(v == 32'hA, "R2 status write leaves preload", v, 32'hA);

        // R3 / R5 sweep of every non-zero preload over two intervals
        for (int p = 1; p < (1 << CNT_W); p++) begin
            wr_reg(0, 32'(p));
            seq_mode = 1'b1;
            iv = p * DIV;
            for (int k = 1; k <= 2 * iv; k++) begin
                @(negedge clk);
                check(busy == 1'b1, "R3 busy while counting", 32'(busy), 32'd1);
                check(next_seq == ((k % iv) == 0), "R5 strobe position",
                      32'(next_seq), 32'((k % iv) == 0));
            end
            seq_mode = 1'b0;
            @(negedge clk);
            check(busy == 1'b0, "R7 stop after sweep", 32'(busy), 32'd0);
        end

        // R2 status busy bit while running
        wr_reg(0, 32'd5);
        seq_mode = 1'b1;
        @(negedge clk);
        rd_reg(1, v); check(v == 32'd1, "R2 status busy bit", v, 32'd1);
        seq_mode = 1'b0;
        @(negedge clk);

        // R4 zero preload blocks start
        wr_reg(0, 32'd0);
        seq_mode = 1'b1;
        expect_quiet(30, "R4 zero preload blocked");
        wr_reg(0, 32'd2);
        for (int k = 1; k <= 8; k++) begin
            @(negedge clk);
            check(busy == 1'b1, "R4 starts after non-zero write", 32'(busy), 32'd1);
            check(next_seq == (k == 8), "R4 first strobe", 32'(next_seq), 32'(k == 8));
        end

        // R9 zero preload at expiry: strobe then park
        for (int k = 1; k <= 20; k++) begin
            @(negedge clk);
            if (k == 2) begin reg_wr = 1'b1; reg_addr = '0; reg_wdata = 32'd0; end
            if (k == 3) reg_wr = 1'b0;
            check(next_seq == (k == 8), "R9 final strobe", 32'(next_seq), 32'(k == 8));
            check(busy == (k <= 8), "R9 parks after expiry", 32'(busy), 32'(k <= 8));
        end
        seq_mode = 1'b0;
        @(negedge clk);

        // R6 preload change mid-interval applies at next reload
        wr_reg(0, 32'd3);
        seq_mode = 1'b1;
        for (int k = 1; k <= 20; k++) begin
            @(negedge clk);
            if (k == 2) begin reg_wr = 1'b1; reg_addr = '0; reg_wdata = 32'd1; end
            if (k == 3) reg_wr = 1'b0;
            check(next_seq == (k == 12 || k == 16 || k == 20), "R6 deferred preload",
                  32'(next_seq), 32'(k == 12 || k == 16 || k == 20));
        end
        seq_mode = 1'b0;
        @(negedge clk);

        // R7 abort mid-interval, then full restart
        wr_reg(0, 32'd3);
        seq_mode = 1'b1;
        for (int k = 1; k <= 5; k++) begin
            @(negedge clk);
            check(next_seq == 1'b0, "R7 no early strobe", 32'(next_seq), 32'd0);
        end
        seq_mode = 1'b0;
        expect_quiet(20, "R7 mode dropped");
        seq_mode = 1'b1;
        for (int k = 1; k <= 12; k++) begin
            @(negedge clk);
            check(next_seq == (k == 12), "R7 fresh interval", 32'(next_seq), 32'(k == 12));
        end
        seq_mode = 1'b0;
        @(negedge clk);

        // R8 synchronous reset mid-interval
        wr_reg(0, 32'd3);
        seq_mode = 1'b1;
        repeat (5) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check(busy == 1'b0, "R8 reset stops", 32'(busy), 32'd0);
        check(next_seq == 1'b0, "R8 reset no strobe", 32'(next_seq), 32'd0);
        rst = 1'b0;
        rd_reg(0, v); check(v == 32'd0, "R8 reset clears preload", v, 32'd0);
        expect_quiet(20, "R8 idle after reset");
        seq_mode = 1'b0;
        @(negedge clk);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule